// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers event pulses from eleven second-level interrupt groups and folds them into one top-level master register. The master register drives a single message-style interrupt request. Each group holds four 32-bit registers on a plain register bus: a status view of the raw inputs, a mask, a latched identity register and an enable. An event is latched into its group's identity register only while its mask bit is clear. Software acknowledges events by writing ones to the identity register.

A group's pending vector is its identity register ANDed with its enable register. Fixed halves or whole words of each pending vector light fixed bits of the master register. Bit 31 of the master register is the only bit that software can store, and it acts as the global enable. Several actions ask for a re-evaluation: an event, a mask write, an enable write or a master write. One clock after that request, the block emits a one-cycle trigger if three things hold. The global enable must be set, some master summary bit must be set, and the 16-bit message control input must hold exactly the value 0x0001.

Top module: `intr_tree_ctrl`

## Requirements
- R1: The status register (group offset 0x0) reads the group's event inputs as sampled on the previous clock edge. Writes to it have no effect.
- R2: An event input bit that is high at a clock edge sets its identity bit (offset 0x8) only if its mask bit (offset 0x4) is 0 at that edge. A masked event is discarded and does not appear after the mask is later cleared.
- R3: A write to the mask or enable (offset 0xC) register replaces the whole stored value, and a read returns that value.
- R4: A write to the identity register clears each bit written as 1 and leaves bits written as 0 unchanged. An unmasked event on the same bit in the same cycle leaves that bit set.
- R5: The master register reads at byte address 0xB0 (group slot 11). Its summary bits come from each group's pending vector (identity AND enable), and they reflect the current register contents with no added delay. The routing is:
  - group 0: bits 15:0 to master bit 0, bits 31:16 to master bit 1;
  - group 1: bits 15:0 to master bit 2, bits 31:16 to master bit 3;
  - group 2: bits 15:0 to master bit 4;
  - group 3: bits 15:0 to master bit 6;
  - groups 4, 5 and 6 (whole word) to master bits 16, 17 and 18;
  - group 7 to bit 20, group 8 to bit 22, group 9 to bit 23, group 10 to bit 30;
  - all other summary bits read 0.
- R6: A master write stores only bit 31 of the write data, which is the global enable. Every other bit of the master register ignores the write.
- R7: The following actions are evaluation actions, counted at a clock edge:
  - any event input high;
  - a write to a mask register;
  - a write to an enable register;
  - a write to the master register.

  After each one, irq_trig is high for the following cycle only if, at the next edge, the global enable is 1 and some master summary bit is 1 and msg_ctrl is valid. Identity writes and status writes are not evaluation actions.
- R8: msg_ctrl is valid only when bit 0 is 1 and bits 15:1 are all 0. Any other value suppresses the trigger.
- R9: Synchronous active-low reset clears every register and holds irq_trig low.
- R10: Group g occupies byte addresses g*0x10 to g*0x10+0xC. Addresses outside the groups and the master register read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 11*32 | Event pulses, group g on bits g*32+31 down to g*32 |
| msg_ctrl | input | 16 | Message control field gating the trigger |
| irq_trig | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with the default ADDR_W of 8. This gives sixteen 16-byte slots: eleven groups, the master at slot 11, and four unused slots above it, so accesses that land outside every register are reachable. With all eleven groups present at full 32-bit width, the bench can exercise every master routing entry, including the unrouted high halves of groups 2 and 3. A behavioural reference model is compared with the trigger and the read data on every clock. Directed sequences cover masking, clearing on acknowledge while an event arrives, and each invalid control pattern.

// File: rtl/intr_tree_pkg.sv
// Shared constants, types and the fixed master routing table for the
// two-level interrupt aggregation controller.
// Assumes group registers and the master register share one data width.
package intr_tree_pkg;

    localparam int REG_W         = 32;
    localparam int GRP_W         = REG_W;
    localparam int N_GRP         = 11;
    localparam int CTRL_W        = 16;
    localparam int MASTER_EN_BIT = REG_W - 1;
    localparam int GRP_IDX_W     = $clog2(N_GRP + 1);
    localparam int MBIT_W        = $clog2(REG_W);
    localparam int SLOT_BYTES    = 16;

    // Register selector taken from address bits [3:2]
    typedef enum logic [1:0] {
        SEL_STAT  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_IDENT = 2'd2,
        SEL_EN    = 2'd3
    } reg_sel_e;

    // Which part of a group's pending vector feeds a master bit
    typedef enum logic [1:0] {
        PART_LO  = 2'd0,
        PART_HI  = 2'd1,
        PART_ALL = 2'd2
    } part_e;

    typedef struct packed {
        logic [GRP_IDX_W-1:0] grp;
        logic [MBIT_W-1:0]    mbit;
        part_e                part;
    } route_t;

    localparam int N_ROUTE = 13;

    // Fixed routing of group pending vectors into master summary bits
    localparam route_t ROUTES [N_ROUTE] = '{
        '{grp: GRP_IDX_W'(0),  mbit: MBIT_W'(0),  part: PART_LO},
        '{grp: GRP_IDX_W'(0),  mbit: MBIT_W'(1),  part: PART_HI},
        '{grp: GRP_IDX_W'(1),  mbit: MBIT_W'(2),  part: PART_LO},
        '{grp: GRP_IDX_W'(1),  mbit: MBIT_W'(3),  part: PART_HI},
        '{grp: GRP_IDX_W'(2),  mbit: MBIT_W'(4),  part: PART_LO},
        '{grp: GRP_IDX_W'(3),  mbit: MBIT_W'(6),  part: PART_LO},
        '{grp: GRP_IDX_W'(4),  mbit: MBIT_W'(16), part: PART_ALL},
        '{grp: GRP_IDX_W'(5),  mbit: MBIT_W'(17), part: PART_ALL},
        '{grp: GRP_IDX_W'(6),  mbit: MBIT_W'(18), part: PART_ALL},
        '{grp: GRP_IDX_W'(7),  mbit: MBIT_W'(20), part: PART_ALL},
        '{grp: GRP_IDX_W'(8),  mbit: MBIT_W'(22), part: PART_ALL},
        '{grp: GRP_IDX_W'(9),  mbit: MBIT_W'(23), part: PART_ALL},
        '{grp: GRP_IDX_W'(10), mbit: MBIT_W'(30), part: PART_ALL}
    };

    // Bit mask selecting the routed part of a pending vector
    function automatic logic [GRP_W-1:0] part_mask(input part_e p);
        logic [GRP_W-1:0] lo;
        lo = {{(GRP_W/2){1'b0}}, {(GRP_W/2){1'b1}}};
        case (p)
            PART_LO: return lo;
            PART_HI: return ~lo;
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/intr_group.sv
// One second-level interrupt group: status sample, mask, identity and
// enable registers, plus its read value and pending vector.
// Assumes the caller qualifies wr_hit with the group's address slot.
module intr_group
    import intr_tree_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] evt,
    input  logic             wr_hit,
    input  reg_sel_e         sel,
    input  logic [GRP_W-1:0] wdata,
    output logic [GRP_W-1:0] rd_val,
    output logic [GRP_W-1:0] pending
);

    logic [GRP_W-1:0] stat_q;
    logic [GRP_W-1:0] mask_q;
    logic [GRP_W-1:0] ident_q;
    logic [GRP_W-1:0] en_q;
    logic [GRP_W-1:0] ack_clr;
    logic [GRP_W-1:0] ident_d;

    // Sample the raw event inputs for the status view
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= evt;
    end

    // Mask register, full replace on write
    always_ff @(posedge clk) begin
        if (!rst_n)                         mask_q <= '0;
        else if (wr_hit && sel == SEL_MASK) mask_q <= wdata;
    end

    // Enable register, full replace on write
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_q <= '0;
        else if (wr_hit && sel == SEL_EN) en_q <= wdata;
    end

    // Next identity value: acknowledge clears, unmasked events set
    always_comb begin
        ack_clr = (wr_hit && sel == SEL_IDENT) ? wdata : '0;
        ident_d = (ident_q & ~ack_clr) | (evt & ~mask_q);
    end

    // Identity register update
    always_ff @(posedge clk) begin
        if (!rst_n) ident_q <= '0;
        else        ident_q <= ident_d;
    end

    // Pending vector seen by the master routing
    assign pending = ident_q & en_q;

    // Read selection inside the group
    always_comb begin
        case (sel)
            SEL_STAT:  rd_val = stat_q;
            SEL_MASK:  rd_val = mask_q;
            SEL_IDENT: rd_val = ident_q;
            default:   rd_val = en_q;
        endcase
    end

endmodule

// File: rtl/intr_route.sv
// Folds the group pending vectors into master summary bits using the
// fixed routing table; purely combinational.
// Assumes every routed master bit appears once in the table.
module intr_route
    import intr_tree_pkg::*;
(
    input  logic [N_GRP*GRP_W-1:0] pend_flat,
    output logic [REG_W-1:0]       summary
);

    logic [N_ROUTE-1:0] route_hit;

    // One intersection test per routing entry
    for (genvar r = 0; r < N_ROUTE; r++) begin : g_route
        assign route_hit[r] =
            |(pend_flat[int'(ROUTES[r].grp)*GRP_W +: GRP_W] & part_mask(ROUTES[r].part));
    end

    // Scatter the hits into their master bit positions
    always_comb begin
        summary = '0;
        for (int r = 0; r < N_ROUTE; r++) begin
            summary[ROUTES[r].mbit] = route_hit[r];
        end
    end

endmodule

// File: rtl/intr_irq_pulse.sv
// Turns an evaluation request into a one-cycle trigger one clock later,
// gated by the global enable, any summary bit and the message control.
// Assumes eval_req is a single-cycle indication per evaluating action.
module intr_irq_pulse
    import intr_tree_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_req,
    input  logic              master_en,
    input  logic [REG_W-1:0]  summary,
    input  logic [CTRL_W-1:0] msg_ctrl,
    output logic              irq_trig
);

    localparam logic [CTRL_W-1:0] CTRL_VALID = CTRL_W'(1);

    logic eval_q;
    logic trig_q;
    logic fire_ok;

    // Remember that an evaluation is owed on the next edge
    always_ff @(posedge clk) begin
        if (!rst_n) eval_q <= 1'b0;
        else        eval_q <= eval_req;
    end

    // Gate condition on the state after the evaluating action
    assign fire_ok = master_en && (|summary) && (msg_ctrl == CTRL_VALID);

    // Register the one-cycle trigger
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= eval_q && fire_ok;
    end

    assign irq_trig = trig_q;

endmodule

// File: rtl/intr_tree_ctrl.sv
// Top of the two-level interrupt aggregation controller: address decode,
// group instances, master enable register, routing and trigger pulse.
// Assumes 16-byte slots per group; the master sits in slot N_GRP, offset 0.
module intr_tree_ctrl
    import intr_tree_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [REG_W-1:0]       bus_wdata,
    input  logic                   bus_we,
    output logic [REG_W-1:0]       bus_rdata,
    input  logic [N_GRP*GRP_W-1:0] evt_in,
    input  logic [CTRL_W-1:0]      msg_ctrl,
    output logic                   irq_trig
);

    localparam int SLOT_W = ADDR_W - $clog2(SLOT_BYTES);

    logic [SLOT_W-1:0]      slot;
    reg_sel_e               sel;
    logic                   grp_space;
    logic                   master_hit;
    logic                   eval_req;
    logic                   master_en_q;
    logic [REG_W-1:0]       summary;
    logic [REG_W-1:0]       master_view;
    logic [N_GRP*GRP_W-1:0] pend_flat;
    logic [GRP_W-1:0]       grp_rd [N_GRP];

    // Address decode into slot and register selector
    always_comb begin
        slot       = bus_addr[ADDR_W-1:$clog2(SLOT_BYTES)];
        sel        = reg_sel_e'(bus_addr[3:2]);
        grp_space  = (slot < SLOT_W'(N_GRP));
        master_hit = (slot == SLOT_W'(N_GRP)) && (sel == SEL_STAT);
    end

    // Group register banks
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        intr_group u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_in[g*GRP_W +: GRP_W]),
            .wr_hit  (bus_we && (slot == SLOT_W'(g))),
            .sel     (sel),
            .wdata   (bus_wdata),
            .rd_val  (grp_rd[g]),
            .pending (pend_flat[g*GRP_W +: GRP_W])
        );
    end

    // Master global enable, the only software-writable master bit
    always_ff @(posedge clk) begin
        if (!rst_n)                    master_en_q <= 1'b0;
        else if (bus_we && master_hit) master_en_q <= bus_wdata[MASTER_EN_BIT];
    end

    // Summary bits from the routing table
    intr_route u_route (
        .pend_flat (pend_flat),
        .summary   (summary)
    );

    // Master register as seen by software
    always_comb begin
        master_view                = summary;
        master_view[MASTER_EN_BIT] = master_en_q;
    end

    // Actions that call for a re-evaluation of the request
    assign eval_req = (|evt_in)
                   || (bus_we && grp_space && (sel == SEL_MASK || sel == SEL_EN))
                   || (bus_we && master_hit);

    // Trigger pulse generation
    intr_irq_pulse u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_req  (eval_req),
        .master_en (master_en_q),
        .summary   (summary),
        .msg_ctrl  (msg_ctrl),
        .irq_trig  (irq_trig)
    );

    // Read data selection across groups and master
    always_comb begin
        bus_rdata = '0;
        if (master_hit) bus_rdata = master_view;
        for (int g = 0; g < N_GRP; g++) begin
            if (slot == SLOT_W'(g)) bus_rdata = grp_rd[g];
        end
    end

endmodule

// File: rtl/intr_tree_chk.sv
// Assertion checker for intr_tree_ctrl, attached through bind.
// Observes only the top-level ports.
module intr_tree_chk
    import intr_tree_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [REG_W-1:0]       bus_wdata,
    input logic                   bus_we,
    input logic [REG_W-1:0]       bus_rdata,
    input logic [N_GRP*GRP_W-1:0] evt_in,
    input logic [CTRL_W-1:0]      msg_ctrl,
    input logic                   irq_trig
);

    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] c_slot;
    logic [1:0]        c_sel;
    logic              c_mst;
    logic              c_act;

    // Port-level view of decode and evaluating actions
    always_comb begin
        c_slot = bus_addr[ADDR_W-1:4];
        c_sel  = bus_addr[3:2];
        c_mst  = (c_slot == SLOT_W'(N_GRP)) && (c_sel == 2'd0);
        c_act  = (|evt_in)
              || (bus_we && (c_slot < SLOT_W'(N_GRP)) && (c_sel == 2'd1 || c_sel == 2'd3))
              || (bus_we && c_mst);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq_trig); // R9

    AST_TRIG_CTRL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_trig |-> ($past(msg_ctrl) == CTRL_W'(1))); // R8

    AST_TRIG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_trig |-> $past(c_act, 2)); // R7

    AST_STATUS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bus_addr == '0) |-> (bus_rdata == $past(evt_in[GRP_W-1:0]))); // R1

    AST_MASTER_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && c_mst) |=> (!c_mst || bus_rdata[MASTER_EN_BIT] == $past(bus_wdata[MASTER_EN_BIT]))); // R6

endmodule

bind intr_tree_ctrl intr_tree_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .msg_ctrl  (msg_ctrl),
    .irq_trig  (irq_trig)
);

// File: tb/sim_intr_tree_ctrl.sv
// Self-checking bench: behavioural reference model compared every clock,
// plus directed checks tagged by requirement.
module sim_intr_tree_ctrl;
    import intr_tree_pkg::*;

    localparam int AW = 8;
    localparam logic [7:0] MST = 8'hB0;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [AW-1:0]     bus_addr;
    logic [31:0]       bus_wdata;
    logic              bus_we;
    logic [31:0]       bus_rdata;
    logic [N_GRP*32-1:0] evt_in;
    logic [15:0]       msg_ctrl;
    logic              irq_trig;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #10 clk = ~clk;

    intr_tree_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .msg_ctrl(msg_ctrl), .irq_trig(irq_trig)
    );

    // Reference model state
    int unsigned m_stat [N_GRP];
    int unsigned m_mask [N_GRP];
    int unsigned m_id   [N_GRP];
    int unsigned m_en   [N_GRP];
    bit m_men, m_eval, m_trig;

    function automatic int unsigned m_sum();
        int unsigned p [N_GRP];
        int unsigned s;
        for (int g = 0; g < N_GRP; g++) p[g] = m_id[g] & m_en[g];
        s = 0;
        if (p[0] & 32'h0000FFFF) s |= 32'h00000001;
        if (p[0] & 32'hFFFF0000) s |= 32'h00000002;
        if (p[1] & 32'h0000FFFF) s |= 32'h00000004;
        if (p[1] & 32'hFFFF0000) s |= 32'h00000008;
        if (p[2] & 32'h0000FFFF) s |= 32'h00000010;
        if (p[3] & 32'h0000FFFF) s |= 32'h00000040;
        if (p[4] != 0)  s |= 32'h00010000;
        if (p[5] != 0)  s |= 32'h00020000;
        if (p[6] != 0)  s |= 32'h00040000;
        if (p[7] != 0)  s |= 32'h00100000;
        if (p[8] != 0)  s |= 32'h00400000;
        if (p[9] != 0)  s |= 32'h00800000;
        if (p[10] != 0) s |= 32'h40000000;
        return s;
    endfunction

    function automatic int unsigned exp_rd(input logic [7:0] a);
        int g, s;
        g = int'(a[7:4]);
        s = int'(a[3:2]);
        if (g < N_GRP) begin
            case (s)
                0: return m_stat[g];
                1: return m_mask[g];
                2: return m_id[g];
                default: return m_en[g];
            endcase
        end
        if (g == N_GRP && s == 0) return (m_men ? 32'h80000000 : 0) | m_sum();
        return 0;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        int g, s;
        g = int'(a[7:4]);
        s = int'(a[3:2]);
        if (g == N_GRP && s == 0) return "R5";
        if (g >= N_GRP) return "R10";
        case (s)
            0: return "R1";
            2: return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on every clock edge
    always @(posedge clk) begin : model
        int ws, ss;
        int unsigned ev, clr;
        if (!rst_n) begin
            for (int g = 0; g < N_GRP; g++) begin
                m_stat[g] = 0; m_mask[g] = 0; m_id[g] = 0; m_en[g] = 0;
            end
            m_men = 0; m_eval = 0; m_trig = 0;
        end else begin
            ws = int'(bus_addr[7:4]);
            ss = int'(bus_addr[3:2]);
            m_trig = m_eval && m_men && (m_sum() != 0) && (msg_ctrl == 16'h0001);
            m_eval = (evt_in != 0)
                  || (bus_we && ws < N_GRP && (ss == 1 || ss == 3))
                  || (bus_we && ws == N_GRP && ss == 0);
            for (int g = 0; g < N_GRP; g++) begin
                ev  = evt_in[g*32 +: 32];
                clr = (bus_we && ws == g && ss == 2) ? bus_wdata : 0;
                m_id[g]   = (m_id[g] & ~clr) | (ev & ~m_mask[g]);
                m_stat[g] = ev;
            end
            if (bus_we && ws < N_GRP && ss == 1) m_mask[ws] = bus_wdata;
            if (bus_we && ws < N_GRP && ss == 3) m_en[ws]   = bus_wdata;
            if (bus_we && ws == N_GRP && ss == 0) m_men = bus_wdata[31];
        end
    end

    // Compare trigger and read data against the model every clock
    always @(posedge clk) begin
        #5;
        if (cmp_on && !done) begin
            chk("R7", {31'b0, irq_trig}, {31'b0, m_trig});
            chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
        end
    end

    function automatic logic [7:0] ra(input int g, input int s);
        return 8'(g * 16 + s * 4);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(input int g, input logic [31:0] bits);
        @(negedge clk);
        evt_in[g*32 +: 32] = bits;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input int g, input logic [31:0] bits);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        evt_in[g*32 +: 32] = bits;
        @(negedge clk);
        bus_we = 1'b0; evt_in = '0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic trig_next(input logic exp, input string tag);
        @(negedge clk);
        #2;
        chk(tag, {31'b0, irq_trig}, {31'b0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    // Directed stimulus
    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
        evt_in = '0; msg_ctrl = 16'h0001;
        repeat (3) @(negedge clk);
        #2;
        chk("R9", {31'b0, irq_trig}, 32'h0);
        rd_chk(MST, 32'h0, "R9");
        rd_chk(ra(0, 2), 32'h0, "R9");
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;

        // Mask and enable full replace
        wr(ra(0, 1), 32'h00000010);
        rd_chk(ra(0, 1), 32'h00000010, "R3");
        wr(ra(0, 3), 32'hFFFFFFFF);
        rd_chk(ra(0, 3), 32'hFFFFFFFF, "R3");

        // Event latching with mask, status sampling
        pulse(0, 32'h00000011);
        rd_chk(ra(0, 0), 32'h00000011, "R1");
        rd_chk(ra(0, 2), 32'h00000001, "R2");
        wr(ra(0, 1), 32'h0);
        rd_chk(ra(0, 2), 32'h00000001, "R2");
        rd_chk(MST, 32'h00000001, "R5");
        trig_next(1'b0, "R7");

        // Global enable write: only bit 31 kept, fires the trigger
        wr(MST, 32'hFFFFFFFF);
        rd_chk(MST, 32'h80000001, "R6");
        trig_next(1'b1, "R7");
        trig_next(1'b0, "R7");

        // High half of group 0, then acknowledge it
        pulse(0, 32'h00010000);
        rd_chk(MST, 32'h80000003, "R5");
        trig_next(1'b1, "R7");
        wr(ra(0, 2), 32'h00010000);
        rd_chk(ra(0, 2), 32'h00000001, "R4");
        rd_chk(MST, 32'h80000001, "R5");
        trig_next(1'b0, "R7");

        // Acknowledge and event on the same bit in the same cycle
        wr_evt(ra(0, 2), 32'h00000101, 0, 32'h00000100);
        rd_chk(ra(0, 2), 32'h00000100, "R4");

        // Message control gating
        msg_ctrl = 16'h0003;
        pulse(0, 32'h00000001);
        trig_next(1'b0, "R8");
        msg_ctrl = 16'h0000;
        pulse(0, 32'h00000001);
        trig_next(1'b0, "R8");
        msg_ctrl = 16'h0001;
        pulse(0, 32'h00000001);
        trig_next(1'b1, "R7");

        // Clear group 0, then walk the routing table
        wr(ra(0, 2), 32'hFFFFFFFF);
        rd_chk(MST, 32'h80000000, "R5");
        for (int g = 1; g < N_GRP; g++) wr(ra(g, 3), 32'hFFFFFFFF);
        pulse(1, 32'h00100000);
        rd_chk(MST, 32'h80000008, "R5");
        pulse(1, 32'h00000001);
        rd_chk(MST, 32'h8000000C, "R5");
        pulse(2, 32'h00100000);
        rd_chk(MST, 32'h8000000C, "R5");
        pulse(2, 32'h00000002);
        rd_chk(MST, 32'h8000001C, "R5");
        pulse(3, 32'h00000008);
        rd_chk(MST, 32'h8000005C, "R5");
        pulse(4, 32'h80000000);
        rd_chk(MST, 32'h8001005C, "R5");
        pulse(5, 32'h00000001);
        rd_chk(MST, 32'h8003005C, "R5");
        pulse(6, 32'h00000001);
        rd_chk(MST, 32'h8007005C, "R5");
        pulse(7, 32'h02000000);
        rd_chk(MST, 32'h8017005C, "R5");
        pulse(8, 32'h00000001);
        rd_chk(MST, 32'h8057005C, "R5");
        pulse(9, 32'h00000001);
        rd_chk(MST, 32'h80D7005C, "R5");
        pulse(10, 32'h01000000);
        rd_chk(MST, 32'hC0D7005C, "R5");

        // Enable write removes group 7 from the summary and re-evaluates
        wr(ra(7, 3), 32'h0);
        rd_chk(MST, 32'hC0C7005C, "R3");
        trig_next(1'b1, "R7");

        // Unmapped addresses and status writes
        wr(8'hC0, 32'hFFFFFFFF);
        rd_chk(8'hC0, 32'h0, "R10");
        wr(8'hB4, 32'h0);
        rd_chk(8'hB4, 32'h0, "R10");
        rd_chk(MST, 32'hC0C7005C, "R10");
        wr(ra(0, 0), 32'h0000FFFF);
        rd_chk(ra(0, 0), 32'h0, "R1");

        // Disabling the master keeps the summary bits
        wr(MST, 32'h7FFFFFFF);
        rd_chk(MST, 32'h40C7005C, "R6");
        trig_next(1'b0, "R7");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule